// File: doc/BRIEF.md
# Delayed Write Completion Matcher

This block sits on the initiator side of a bus bridge and looks after the delayed write request that is at the head of the bridge's write queue. The queue presents the head entry, which is its address, command, data and byte enables. The block latches that entry and waits for the target side to send back the final completion status. While it waits, the initiator retries the same write again and again. The block compares each retry with the latched entry.

A retry that matches and whose data parity is good is answered with a target-ready strobe. The stored status is returned with that strobe, and a one-cycle dequeue pulse retires the entry. A retry that matches but carries bad parity also gets target-ready, but no status is returned and the entry stays queued. In that case the parity-error strobe follows two cycles after target-ready, provided the parity-error-response enable is set. If the target side reported a parity error when it delivered the write, that error goes back to the initiator on the completing retry. Any other retry is told to try again. If an entry is held too long without being retired, a master-timeout counter drops it and raises a system-error pulse.

Top module: `delayedWriteMatcher`

## Requirements
- R1: A retry that matches on address, command, data and byte enables, arrives after the completion status is back, and has good parity gives `trdy`, `statusValid` with the stored `statusOut`, and `dequeue`. All three are high for exactly the one cycle after the clock edge that samples the retry, and the entry is released.
- R2: The parity bit takes no part in the match. A retry whose four fields are equal but whose parity bit is wrong is still answered with `trdy`, not `stop`.
- R3: A retry that differs in any one of address, command, data or byte enables is answered with `stop` alone. No state changes, so a later matching retry still completes.
- R4: Parity is even over `{retryData, retryBe}`: a parity error means `retryPar` differs from the XOR of those bits. A matching retry with a parity error gives `trdy` without `statusValid` or `dequeue`, and the entry remains held.
- R5: After `trdy` for a retry that carries a parity error or a forwarded target error, `perrStrobe` rises exactly two cycles later, but only if `perrRespEn` was set when the retry was sampled. In every other case it stays low.
- R6: `stsPerrDetected` is set by every matching retry with a parity error, whatever the state of `perrRespEn`. It stays set until a cycle with `clrPerrDetected` high.
- R7: A target-side parity error (`donePerr`) is stored with the completion status. The next clean matching retry still retires the entry with its status and also raises `perrStrobe` as in R5. `stsDataPerr` becomes set when that completion arrives, but only if `perrRespEn` is high; it is cleared by `clrDataPerr`.
- R8: A matching retry that arrives before the completion status has come back is answered with `stop`.
- R9: If an entry is held for TIMEOUT_CYCLES clock edges after the edge that loads it without being retired, `serr` and `dequeue` pulse together for one cycle, `trdy` stays low, and the entry is dropped.
- R10: After reset every strobe and both sticky status bits are low and no entry is held, so any retry gets `stop`.
- R11: A load presented while an entry is held is ignored. The held entry keeps its fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| perrRespEn | input | 1 | Parity-error-response enable |
| loadValid | input | 1 | Queue head presents a new delayed write |
| loadAddr | input | ADDR_W | Head entry address |
| loadCmd | input | CMD_W | Head entry command |
| loadData | input | DATA_W | Head entry data |
| loadBe | input | BE_W | Head entry byte enables |
| doneValid | input | 1 | Completion status arrives from the target side |
| doneStatus | input | STAT_W | Completion status value |
| donePerr | input | 1 | Target side saw a data parity error |
| retryValid | input | 1 | Initiator retry present this cycle |
| retryAddr | input | ADDR_W | Retry address |
| retryCmd | input | CMD_W | Retry command |
| retryData | input | DATA_W | Retry data |
| retryBe | input | BE_W | Retry byte enables |
| retryPar | input | 1 | Retry even-parity bit |
| clrPerrDetected | input | 1 | Write-one-to-clear for stsPerrDetected |
| clrDataPerr | input | 1 | Write-one-to-clear for stsDataPerr |
| trdy | output | 1 | Target-ready strobe to the initiator |
| stop | output | 1 | Retry termination strobe |
| statusValid | output | 1 | statusOut carries the returned write status |
| statusOut | output | STAT_W | Returned write status |
| dequeue | output | 1 | Retire the head entry |
| perrStrobe | output | 1 | Parity-error strobe to the initiator |
| serr | output | 1 | System error pulse on master timeout |
| stsPerrDetected | output | 1 | Sticky parity-error-detected status bit |
| stsDataPerr | output | 1 | Sticky data-parity-detected status bit |

## Verification
The assertions assume that a retry, a load and a completion each last a single cycle. They also assume that `perrRespEn` stays still for the three cycles that follow any retry, so the strobe that appears later can be traced back to the enable that was in force when the retry was sampled. The stimulus holds every request for exactly one clock. It changes the enable only between queue entries, and it waits out the two-cycle parity-error lag before it offers the next retry. In the random phase each entry retires well before the timeout window would run out. Timeout is covered only in a directed case with no retries at all.

// File: rtl/dwmPkg.sv
package dwmPkg;
  typedef struct packed {
    logic captureReq;
    logic captureDone;
  } dwmStrobes_t;
endpackage

// File: rtl/dwmDatapath.sv
module dwmDatapath
  import dwmPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4,
  parameter int STAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dwmStrobes_t       strobes,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [CMD_W-1:0]  loadCmd,
  input  logic [DATA_W-1:0] loadData,
  input  logic [BE_W-1:0]   loadBe,
  input  logic [STAT_W-1:0] doneStatus,
  input  logic              donePerr,
  input  logic [ADDR_W-1:0] retryAddr,
  input  logic [CMD_W-1:0]  retryCmd,
  input  logic [DATA_W-1:0] retryData,
  input  logic [BE_W-1:0]   retryBe,
  input  logic              retryPar,
  output logic              isMatch,
  output logic              parErr,
  output logic [STAT_W-1:0] headStatus,
  output logic              headTgtPerr
);
  localparam int PAR_W = DATA_W + BE_W;

  logic [ADDR_W-1:0] hAddr;
  logic [CMD_W-1:0]  hCmd;
  logic [DATA_W-1:0] hData;
  logic [BE_W-1:0]   hBe;
  logic [PAR_W-1:0]  parVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hAddr       <= '0;
      hCmd        <= '0;
      hData       <= '0;
      hBe         <= '0;
      headStatus  <= '0;
      headTgtPerr <= 1'b0;
    end else begin
      if (strobes.captureReq) begin
        hAddr <= loadAddr;
        hCmd  <= loadCmd;
        hData <= loadData;
        hBe   <= loadBe;
      end
      if (strobes.captureDone) begin
        headStatus  <= doneStatus;
        headTgtPerr <= donePerr;
      end
    end
  end

  // Parity bit deliberately left out of the comparison.
  assign isMatch = (retryAddr == hAddr) && (retryCmd == hCmd) &&
                   (retryData == hData) && (retryBe == hBe);

  assign parVec = {retryData, retryBe};
  assign parErr = (^parVec) != retryPar;
endmodule

// File: rtl/dwmTimer.sv
module dwmTimer #(
  parameter int TIMEOUT_CYCLES = 4096
) (
  input  logic clk,
  input  logic rstN,
  input  logic reload,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       count <= '0;
    else if (reload) count <= '0;
    else if (run)    count <= count + 1'b1;
  end

  assign expire = run && (count == LAST);
endmodule

// File: rtl/dwmControl.sv
module dwmControl
  import dwmPkg::*;
#(
  parameter int STAT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              perrRespEn,
  input  logic              loadValid,
  input  logic              doneValid,
  input  logic              donePerr,
  input  logic              retryValid,
  input  logic              clrPerrDetected,
  input  logic              clrDataPerr,
  input  logic              isMatch,
  input  logic              parErr,
  input  logic [STAT_W-1:0] headStatus,
  input  logic              headTgtPerr,
  input  logic              expire,
  output dwmStrobes_t       strobes,
  output logic              entryValid,
  output logic              trdy,
  output logic              stop,
  output logic              statusValid,
  output logic [STAT_W-1:0] statusOut,
  output logic              dequeue,
  output logic              perrStrobe,
  output logic              serr,
  output logic              stsPerrDetected,
  output logic              stsDataPerr
);
  localparam int LAG = 3;

  logic           doneSeen;
  logic           retryHit;
  logic           cleanHit;
  logic           expireEff;
  logic           perrReq;
  logic [LAG-1:0] perrPipe;

  always_comb begin
    retryHit            = retryValid && entryValid && doneSeen && isMatch;
    cleanHit            = retryHit && !parErr;
    expireEff           = expire && !cleanHit;
    perrReq             = retryHit && perrRespEn && (parErr || headTgtPerr);
    strobes.captureReq  = loadValid && !entryValid;
    strobes.captureDone = doneValid && entryValid && !doneSeen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entryValid      <= 1'b0;
      doneSeen        <= 1'b0;
      trdy            <= 1'b0;
      stop            <= 1'b0;
      statusValid     <= 1'b0;
      statusOut       <= '0;
      dequeue         <= 1'b0;
      serr            <= 1'b0;
      perrPipe        <= '0;
      stsPerrDetected <= 1'b0;
      stsDataPerr     <= 1'b0;
    end else begin
      if (strobes.captureReq)         entryValid <= 1'b1;
      else if (cleanHit || expireEff) entryValid <= 1'b0;

      if (cleanHit || expireEff)       doneSeen <= 1'b0;
      else if (strobes.captureDone)    doneSeen <= 1'b1;

      trdy        <= retryHit;
      stop        <= retryValid && !retryHit;
      statusValid <= cleanHit;
      statusOut   <= cleanHit ? headStatus : '0;
      dequeue     <= cleanHit || expireEff;
      serr        <= expireEff;
      perrPipe    <= {perrPipe[LAG-2:0], perrReq};

      stsPerrDetected <= (stsPerrDetected && !clrPerrDetected) || (retryHit && parErr);
      stsDataPerr     <= (stsDataPerr && !clrDataPerr) ||
                         (strobes.captureDone && donePerr && perrRespEn);
    end
  end

  assign perrStrobe = perrPipe[LAG-1];
endmodule

// File: rtl/delayedWriteMatcher.sv
module delayedWriteMatcher
  import dwmPkg::*;
#(
  parameter int ADDR_W         = 32,
  parameter int CMD_W          = 4,
  parameter int DATA_W         = 32,
  parameter int BE_W           = 4,
  parameter int STAT_W         = 2,
  parameter int TIMEOUT_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              perrRespEn,
  input  logic              loadValid,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [CMD_W-1:0]  loadCmd,
  input  logic [DATA_W-1:0] loadData,
  input  logic [BE_W-1:0]   loadBe,
  input  logic              doneValid,
  input  logic [STAT_W-1:0] doneStatus,
  input  logic              donePerr,
  input  logic              retryValid,
  input  logic [ADDR_W-1:0] retryAddr,
  input  logic [CMD_W-1:0]  retryCmd,
  input  logic [DATA_W-1:0] retryData,
  input  logic [BE_W-1:0]   retryBe,
  input  logic              retryPar,
  input  logic              clrPerrDetected,
  input  logic              clrDataPerr,
  output logic              trdy,
  output logic              stop,
  output logic              statusValid,
  output logic [STAT_W-1:0] statusOut,
  output logic              dequeue,
  output logic              perrStrobe,
  output logic              serr,
  output logic              stsPerrDetected,
  output logic              stsDataPerr
);
  dwmStrobes_t       strobes;
  logic              isMatch;
  logic              parErr;
  logic [STAT_W-1:0] headStatus;
  logic              headTgtPerr;
  logic              entryValid;
  logic              expire;

  dwmDatapath #(
    .ADDR_W(ADDR_W), .CMD_W(CMD_W), .DATA_W(DATA_W), .BE_W(BE_W), .STAT_W(STAT_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .loadAddr(loadAddr), .loadCmd(loadCmd), .loadData(loadData), .loadBe(loadBe),
    .doneStatus(doneStatus), .donePerr(donePerr),
    .retryAddr(retryAddr), .retryCmd(retryCmd), .retryData(retryData),
    .retryBe(retryBe), .retryPar(retryPar),
    .isMatch(isMatch), .parErr(parErr), .headStatus(headStatus), .headTgtPerr(headTgtPerr)
  );

  dwmTimer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk(clk), .rstN(rstN), .reload(strobes.captureReq), .run(entryValid), .expire(expire)
  );

  dwmControl #(.STAT_W(STAT_W)) u_control (
    .clk(clk), .rstN(rstN), .perrRespEn(perrRespEn), .loadValid(loadValid),
    .doneValid(doneValid), .donePerr(donePerr), .retryValid(retryValid),
    .clrPerrDetected(clrPerrDetected), .clrDataPerr(clrDataPerr),
    .isMatch(isMatch), .parErr(parErr), .headStatus(headStatus), .headTgtPerr(headTgtPerr),
    .expire(expire), .strobes(strobes), .entryValid(entryValid),
    .trdy(trdy), .stop(stop), .statusValid(statusValid), .statusOut(statusOut),
    .dequeue(dequeue), .perrStrobe(perrStrobe), .serr(serr),
    .stsPerrDetected(stsPerrDetected), .stsDataPerr(stsDataPerr)
  );
endmodule

// File: rtl/dwmChecker.sv
module dwmChecker (
  input logic clk,
  input logic rstN,
  input logic retryValid,
  input logic perrRespEn,
  input logic trdy,
  input logic stop,
  input logic statusValid,
  input logic dequeue,
  input logic perrStrobe,
  input logic serr
);
  assert_ready_xor_stop_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(trdy && stop));

  assert_ready_needs_retry_R1: assert property (@(posedge clk) disable iff (!rstN)
    trdy |-> $past(retryValid));

  assert_status_with_retire_R1: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |-> (trdy && dequeue));

  assert_perr_lag_R5: assert property (@(posedge clk) disable iff (!rstN)
    perrStrobe |-> $past(trdy, 2));

  assert_perr_enabled_R5: assert property (@(posedge clk) disable iff (!rstN)
    perrStrobe |-> $past(perrRespEn, 3));

  assert_timeout_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    serr |-> (dequeue && !trdy));
endmodule

bind delayedWriteMatcher dwmChecker u_checker (
  .clk(clk), .rstN(rstN), .retryValid(retryValid), .perrRespEn(perrRespEn),
  .trdy(trdy), .stop(stop), .statusValid(statusValid), .dequeue(dequeue),
  .perrStrobe(perrStrobe), .serr(serr)
);

// File: tb/delayedWriteMatcher_test.sv
`timescale 1ns/1ps
module delayedWriteMatcher_test;
  localparam int TO = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        perrRespEn = 1'b0;
  logic        loadValid = 1'b0;
  logic [31:0] loadAddr = '0;
  logic [3:0]  loadCmd = '0;
  logic [31:0] loadData = '0;
  logic [3:0]  loadBe = '0;
  logic        doneValid = 1'b0;
  logic [1:0]  doneStatus = '0;
  logic        donePerr = 1'b0;
  logic        retryValid = 1'b0;
  logic [31:0] retryAddr = '0;
  logic [3:0]  retryCmd = '0;
  logic [31:0] retryData = '0;
  logic [3:0]  retryBe = '0;
  logic        retryPar = 1'b0;
  logic        clrPerrDetected = 1'b0;
  logic        clrDataPerr = 1'b0;
  logic        trdy, stop, statusValid, dequeue, perrStrobe, serr;
  logic        stsPerrDetected, stsDataPerr;
  logic [1:0]  statusOut;

  delayedWriteMatcher #(.TIMEOUT_CYCLES(TO)) uut (.*);

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // bench model of the held entry
  logic [31:0] mAddr, mData;
  logic [3:0]  mCmd, mBe;
  logic [1:0]  mStat;
  bit mValid = 0, mDone = 0, mTgt = 0, mPerrDet = 0, mDataPerr = 0;

  function automatic logic evenPar(logic [31:0] d, logic [3:0] b);
    return ^{d, b};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic checkSticky(string req);
    chk({req, " stsPerrDetected"}, 32'(stsPerrDetected), 32'(mPerrDet));
    chk({req, " stsDataPerr"}, 32'(stsDataPerr), 32'(mDataPerr));
  endtask

  task automatic doLoad(logic [31:0] a, logic [3:0] c, logic [31:0] d, logic [3:0] b);
    @(negedge clk);
    loadValid = 1; loadAddr = a; loadCmd = c; loadData = d; loadBe = b;
    @(negedge clk);
    loadValid = 0;
    if (!mValid) begin
      mValid = 1; mDone = 0; mAddr = a; mCmd = c; mData = d; mBe = b;
    end
  endtask

  task automatic doDone(logic [1:0] st, logic tp);
    @(negedge clk);
    doneValid = 1; doneStatus = st; donePerr = tp;
    @(negedge clk);
    doneValid = 0;
    if (mValid && !mDone) begin
      mDone = 1; mStat = st; mTgt = tp;
      if (tp && perrRespEn) mDataPerr = 1;
    end
    checkSticky("R7 completion");
  endtask

  task automatic doClear(logic cp, logic cd);
    @(negedge clk);
    clrPerrDetected = cp; clrDataPerr = cd;
    @(negedge clk);
    clrPerrDetected = 0; clrDataPerr = 0;
    if (cp) mPerrDet = 0;
    if (cd) mDataPerr = 0;
    checkSticky("R6 R7 clear");
  endtask

  // mode 0: clean copy, 1: bad parity, 2: one field changed
  task automatic doRetry(int mode, string req);
    logic [31:0] a, d;
    logic [3:0]  c, b;
    logic        p, pe, hit, clean, expPerr;
    a = mAddr; c = mCmd; d = mData; b = mBe;
    if (mode == 2) begin
      case ($urandom_range(3, 0))
        0: a[$urandom_range(31, 0)] ^= 1'b1;
        1: c[$urandom_range(3, 0)]  ^= 1'b1;
        2: d[$urandom_range(31, 0)] ^= 1'b1;
        default: b[$urandom_range(3, 0)] ^= 1'b1;
      endcase
    end
    p  = evenPar(d, b) ^ (mode == 1);
    pe = (mode == 1);
    hit = mValid && mDone && (mode != 2);
    clean = hit && !pe;
    expPerr = hit && perrRespEn && (pe || mTgt);
    @(negedge clk);
    retryValid = 1; retryAddr = a; retryCmd = c; retryData = d; retryBe = b; retryPar = p;
    @(negedge clk);
    retryValid = 0;
    if (hit && pe) mPerrDet = 1;
    chk({req, " trdy"}, 32'(trdy), 32'(hit));
    chk({req, " stop"}, 32'(stop), 32'(!hit));
    chk({req, " statusValid"}, 32'(statusValid), 32'(clean));
    if (clean) chk({req, " statusOut"}, 32'(statusOut), 32'(mStat));
    chk({req, " dequeue"}, 32'(dequeue), 32'(clean));
    chk({req, " serr"}, 32'(serr), 0);
    chk("R5 perr not early", 32'(perrStrobe), 0);
    @(negedge clk);
    chk("R5 perr not early", 32'(perrStrobe), 0);
    @(negedge clk);
    chk({"R5 R7 perr lag ", req}, 32'(perrStrobe), 32'(expPerr));
    checkSticky({"R6 ", req});
    if (clean) begin mValid = 0; mDone = 0; end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 trdy", 32'(trdy), 0);
    chk("R10 perrStrobe", 32'(perrStrobe), 0);
    chk("R10 serr", 32'(serr), 0);
    chk("R10 dequeue", 32'(dequeue), 0);
    checkSticky("R10");
    mAddr = 32'h1000; mCmd = 4'h7; mData = 32'hcafe0001; mBe = 4'hf;
    doRetry(0, "R10 empty");

    // R1 / R8 directed
    perrRespEn = 1;
    doLoad(32'h2000, 4'h7, 32'h12345678, 4'h3);
    doRetry(0, "R8 early");
    doDone(2'd2, 1'b0);
    doRetry(2, "R3 mismatch");
    doRetry(0, "R1 clean");
    doRetry(0, "R1 retired");

    // R2 / R4 / R5 / R6 parity error retry then clean
    doLoad(32'h3000, 4'hb, 32'h0f0f0f0f, 4'h1);
    doDone(2'd1, 1'b0);
    doRetry(1, "R2 R4 parity");
    doRetry(0, "R4 still held");
    doClear(1, 0);

    // R5 / R6 with enable off
    perrRespEn = 0;
    doLoad(32'h3100, 4'h3, 32'h0000ffff, 4'h8);
    doDone(2'd3, 1'b1);
    doRetry(1, "R6 parity no enable");
    doRetry(0, "R7 target perr no enable");
    doClear(1, 1);

    // R7 target perr with enable
    perrRespEn = 1;
    doLoad(32'h4000, 4'h6, 32'h55aa55aa, 4'hc);
    doDone(2'd0, 1'b1);
    doRetry(0, "R7 forwarded");
    doClear(0, 1);

    // R11 second load ignored
    doLoad(32'h5000, 4'h2, 32'haaaa0000, 4'hf);
    @(negedge clk);
    loadValid = 1; loadAddr = 32'h6000; loadCmd = 4'h9; loadData = 32'h1; loadBe = 4'h1;
    @(negedge clk);
    loadValid = 0;
    doDone(2'd1, 1'b0);
    @(negedge clk);
    retryValid = 1; retryAddr = 32'h6000; retryCmd = 4'h9; retryData = 32'h1; retryBe = 4'h1;
    retryPar = evenPar(32'h1, 4'h1);
    @(negedge clk);
    retryValid = 0;
    chk("R11 stale load stop", 32'(stop), 1);
    chk("R11 stale load trdy", 32'(trdy), 0);
    doRetry(0, "R11 original");

    // R9 timeout
    doLoad(32'h7000, 4'h1, 32'h77, 4'h2);
    for (int k = 1; k < TO; k++) begin
      @(negedge clk);
      if (serr) chk("R9 serr early", 32'(serr), 0);
    end
    @(negedge clk);
    chk("R9 serr", 32'(serr), 1);
    chk("R9 dequeue", 32'(dequeue), 1);
    chk("R9 trdy", 32'(trdy), 0);
    @(negedge clk);
    chk("R9 serr one cycle", 32'(serr), 0);
    mValid = 0; mDone = 0;
    doRetry(0, "R9 dropped");

    // random phase
    for (int e = 0; e < 40; e++) begin
      perrRespEn = $urandom_range(1, 0);
      doLoad($urandom, 4'($urandom), $urandom, 4'($urandom));
      if ($urandom_range(3, 0) == 0) doRetry(0, "R8 random early");
      doDone(2'($urandom), $urandom_range(3, 0) == 0);
      for (int r = 0, n = $urandom_range(3, 0); r < n; r++)
        doRetry($urandom_range(2, 1), "R3 R4 random");
      doRetry(0, "R1 random");
      if ($urandom_range(3, 0) == 0) doClear($urandom_range(1, 0), $urandom_range(1, 0));
    end

    repeat (4) @(negedge clk);
    finish();
  end
endmodule